// File: doc/BRIEF.md
# Occupancy-Steered Rate Recovery Buffer

This block smooths a bursty, gapped stream of data words into an evenly paced output stream with the same long-term rate. Everything runs on one clock. The incoming "clock" is a write strobe that may skip cycles, and the outgoing "clock" is a read strobe produced inside the block. Words are written into a small first-in first-out store whenever the write strobe is high. They are read out whenever a phase accumulator rolls over.

On every cycle the accumulator adds the current number of stored words to its value. When the sum reaches a programmable modulus, the block subtracts the modulus and issues one read strobe. The loop is therefore purely proportional. A fuller store reads faster, and an emptier one reads slower, until the read rate matches the write rate. At that balance point the average fill equals the modulus divided by the input period. The stored amount therefore scales with the data rate, which keeps the delay through the buffer constant. The modulus sets how many words correspond to a given rate.

Top module: `fifo_rate_dpll`

## Requirements
- R1: While reset is low, and in the first cycle after it rises, rd_en_o, overflow_o and fill_o are all zero.
- R2: fill_o rises by one after a cycle with an accepted write and no read. It falls by one after a read with no write. It is unchanged after a cycle with both or with neither.
- R3: Each cycle the accumulator adds fill_o to its value. When that sum is greater than or equal to modulus_i, rd_en_o is high in that same cycle and the accumulator keeps the sum minus modulus_i. Otherwise it keeps the sum.
- R4: While fill_o is zero, rd_en_o stays low.
- R5: In a cycle with rd_en_o high, rd_data_o holds the oldest stored word. Words leave in the order they were accepted.
- R6: A write in a cycle where fill_o equals DEPTH and rd_en_o is low is dropped. The stored words are left unchanged, and overflow_o is high for exactly the following cycle.
- R7: A write in a cycle where fill_o equals DEPTH and rd_en_o is high is accepted, and no overflow is flagged.
- R8: With one write every P cycles and a constant modulus M, the read count matches the write count once the loop has settled. The time-averaged fill_o is then M/P within one word, so a larger modulus holds more data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Gapped input strobe; writes wr_data_i |
| wr_data_i | input | DATA_W | Word to store |
| modulus_i | input | ACC_W | Accumulator rollover value |
| rd_en_o | output | 1 | Regenerated read strobe |
| rd_data_o | output | DATA_W | Oldest stored word, valid with rd_en_o |
| fill_o | output | CNT_W | Number of stored words, also the phase increment |
| overflow_o | output | 1 | One-cycle flag after a dropped write |

## Verification
The assertions assume that modulus_i is at least DEPTH, is nonzero, and changes only while reset is low. Under those conditions one cycle can produce at most one rollover, and the accumulator always stays below the modulus. The bench loads a new modulus only inside its reset task, and it never uses a value below DEPTH. It compares every cycle against an independent model of the store and the accumulator. It drives continuous bursts into a store that is already full to reach the dropped-write and the simultaneous read-and-write cases.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_DEPTH  = 16;
    localparam int unsigned DEF_ACC_W  = 12;
endpackage

// File: rtl/occ_fifo.sv
module occ_fifo #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CNT_W-1:0]  fill_o,
    output logic              ovf_o
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] fill;
        logic             ovf;
    } fifo_state_t;

    fifo_state_t       st_q, st_d;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              accept;

    always_comb begin
        st_d   = st_q;
        accept = push_i && ((st_q.fill != FULL_CNT) || pop_i);
        if (accept) st_d.wr_ptr = st_q.wr_ptr + PTR_W'(1);
        if (pop_i)  st_d.rd_ptr = st_q.rd_ptr + PTR_W'(1);
        if (accept && !pop_i)      st_d.fill = st_q.fill + CNT_W'(1);
        else if (pop_i && !accept) st_d.fill = st_q.fill - CNT_W'(1);
        st_d.ovf = push_i && !accept;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem_q[st_q.wr_ptr] <= data_i;
    end

    assign data_o = mem_q[st_q.rd_ptr];
    assign fill_o = st_q.fill;
    assign ovf_o  = st_q.ovf;

    // R4: the read side never pulls from an empty store
    a_r4_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (st_q.fill != '0));
    // R6: a drop flag only follows a cycle that was full with no read
    a_r6_ovf_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && st_q.fill == FULL_CNT && !pop_i) |=> ovf_o);
    // R7: a full store that is also being read accepts the write
    a_r7_full_with_read_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> (!ovf_o && $stable(fill_o)));
    // R2: a lone accepted write raises the count by one
    a_r2_fill_up: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && st_q.fill != FULL_CNT) |=> (fill_o == $past(fill_o) + CNT_W'(1)));
endmodule

// File: rtl/phase_acc.sv
module phase_acc #(
    parameter int unsigned ACC_W = 12,
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] inc_i,
    input  logic [ACC_W-1:0] modulus_i,
    output logic             fire_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } acc_state_t;

    acc_state_t     st_q, st_d;
    logic [ACC_W:0] inc_x, mod_x, sum, wrapped;
    logic           fire;

    always_comb begin
        inc_x   = {{(ACC_W + 1 - CNT_W){1'b0}}, inc_i};
        mod_x   = {1'b0, modulus_i};
        sum     = {1'b0, st_q.acc} + inc_x;
        wrapped = sum - mod_x;
        fire    = (inc_i != '0) && (sum >= mod_x);
        st_d    = st_q;
        st_d.acc = fire ? wrapped[ACC_W-1:0] : sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire_o = fire;

    // R3: the phase stays below the rollover value (modulus >= depth, held during run)
    a_r3_acc_below_modulus: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.acc < modulus_i));
    // R4: no increment, no strobe
    a_r4_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i == '0) |-> !fire_o);
    // R3: with no strobe the phase grows by exactly the increment
    a_r3_phase_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_o |=> (st_q.acc == $past(st_q.acc) + ACC_W'($past(inc_i))));
endmodule

// File: rtl/fifo_rate_dpll.sv
module fifo_rate_dpll #(
    parameter int unsigned DATA_W = dpll_pkg::DEF_DATA_W,
    parameter int unsigned DEPTH  = dpll_pkg::DEF_DEPTH,
    parameter int unsigned ACC_W  = dpll_pkg::DEF_ACC_W,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ACC_W-1:0]  modulus_i,
    output logic              rd_en_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  fill_o,
    output logic              overflow_o
);
    logic             fire;
    logic [CNT_W-1:0] fill;

    occ_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (wr_en_i),
        .data_i (wr_data_i),
        .pop_i  (fire),
        .data_o (rd_data_o),
        .fill_o (fill),
        .ovf_o  (overflow_o)
    );

    phase_acc #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (fill),
        .modulus_i (modulus_i),
        .fire_o    (fire)
    );

    assign rd_en_o = fire;
    assign fill_o  = fill;

    // R6: the drop flag lasts one cycle unless a second drop follows
    a_r6_flag_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !wr_en_i) |=> !overflow_o);
endmodule

// File: tb/tb_fifo_rate_dpll.sv
module tb_fifo_rate_dpll;
    localparam int DW = 8;
    localparam int DEPTH = 16;
    localparam int AW = 12;
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] modulus = AW'(16);
    logic          rd_en;
    logic [DW-1:0] rd_data;
    logic [CW-1:0] fill;
    logic          ovf;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    int mq [DEPTH];
    int mhead, mtail, mfill, macc, mmod;
    bit movf;
    int ovf_seen, r7_hits, reads_seen, fill_sum;

    always #5 clk = ~clk;

    fifo_rate_dpll dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .modulus_i(modulus), .rd_en_o(rd_en), .rd_data_o(rd_data),
        .fill_o(fill), .overflow_o(ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input int m);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; modulus = AW'(m);
        mmod = m; mhead = 0; mtail = 0; mfill = 0; macc = 0; movf = 0;
        repeat (2) @(negedge clk);
        chk(rd_en == 1'b0, "R1 rd_en in reset", int'(rd_en), 0);
        chk(fill == '0, "R1 fill in reset", int'(fill), 0);
        chk(ovf == 1'b0, "R1 overflow in reset", int'(ovf), 0);
        rst_n = 1'b1;
    endtask

    // one cycle: drive, compare with model, advance model
    task automatic step(input bit wr, input int d);
        bit fire, acc;
        int sum;
        @(negedge clk);
        wr_en = wr; wr_data = DW'(d);
        #1;
        sum = macc + mfill;
        fire = (mfill != 0) && (sum >= mmod);
        if (mfill == 0) chk(rd_en == 1'b0, "R4 no read when empty", int'(rd_en), 0);
        else            chk(rd_en == fire, "R3 rollover strobe", int'(rd_en), int'(fire));
        if (fire && rd_en) chk(int'(rd_data) == mq[mhead], "R5 oldest word", int'(rd_data), mq[mhead]);
        chk(int'(fill) == mfill, "R2 fill count", int'(fill), mfill);
        chk(ovf == movf, "R6 overflow flag", int'(ovf), int'(movf));
        if (rd_en) reads_seen++;
        if (ovf) ovf_seen++;
        fill_sum += int'(fill);
        macc = fire ? sum - mmod : sum;
        acc = wr && ((mfill < DEPTH) || fire);
        if (wr && mfill == DEPTH && fire) r7_hits++;
        if (fire) mhead = (mhead + 1) % DEPTH;
        if (acc) begin mq[mtail] = d % 256; mtail = (mtail + 1) % DEPTH; end
        mfill = mfill + int'(acc) - int'(fire);
        movf = wr && !acc;
    endtask

    task automatic t_empty_idle();
        do_reset(16);
        reads_seen = 0;
        for (int i = 0; i < 40; i++) step(1'b0, 0);
        chk(reads_seen == 0, "R4 idle empty store", reads_seen, 0);
    endtask

    task automatic t_single_word();
        do_reset(20);
        reads_seen = 0;
        step(1'b1, 8'h5A);
        for (int i = 0; i < 30; i++) step(1'b0, 0);
        chk(reads_seen == 1, "R3 one word one strobe", reads_seen, 1);
    endtask

    task automatic t_burst_order();
        do_reset(16);
        for (int i = 0; i < 12; i++) step(1'b1, 16'h30 + i);
        for (int i = 0; i < 60; i++) step(1'b0, 0);
        chk(mfill == int'(fill), "R2 drained count", int'(fill), mfill);
    endtask

    task automatic t_overflow();
        do_reset(255);
        ovf_seen = 0; r7_hits = 0;
        for (int i = 0; i < 120; i++) step(1'b1, 16'h80 + i);
        chk(ovf_seen > 0, "R6 dropped writes flagged", ovf_seen, 1);
        chk(r7_hits > 0, "R7 full write during read", r7_hits, 1);
        for (int i = 0; i < 40; i++) step(1'b0, 0);
        chk(ovf == 1'b0, "R6 flag clears", int'(ovf), 0);
    endtask

    task automatic t_rate(input int m);
        do_reset(m);
        for (int i = 0; i < 1200; i++) begin
            if (i == 944) begin reads_seen = 0; fill_sum = 0; end
            step((i % 8) == 0, i);
        end
        chk(reads_seen >= 31 && reads_seen <= 33, "R8 read count", reads_seen, 32);
        chk(fill_sum >= (m / 8 - 1) * 256 && fill_sum <= (m / 8 + 1) * 256,
            "R8 average fill x256", fill_sum, (m / 8) * 256);
    endtask

    initial begin
        t_empty_idle();
        t_single_word();
        t_burst_order();
        t_overflow();
        t_rate(32);
        t_rate(64);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule